// File: doc/BRIEF.md
# Dual-Channel IDE Bus-Master Register Block

This block holds the byte-wide control registers for a two-channel IDE bus-master DMA controller. It also merges the two channel interrupts into one level-sensitive PCI interrupt line. A host issues single-byte reads and writes through a strobe port. Bit 3 of the address picks the channel, so the channel 1 window starts 8 bytes above the channel 0 window. The low two address bits pick one of four registers in that window. Each channel has a command byte that is only stored, a status byte with mixed write rules, and a timing byte. A single mode byte appears in both windows. It holds the latched pending flag of each channel and a host-controlled block flag for each channel.

The transfer engine is not part of this block. It reaches the status byte through per-channel set pulses. Each channel's interrupt wire drives the pending flag in the mode byte. The interrupt output is high when some channel is pending and not blocked.

A small access state machine follows the host port. From **HP_IDLE** it moves to **HP_READ** on a read strobe (transition *rd_strobe*) or to **HP_WRITE** on a write strobe (transition *wr_strobe*). It returns to **HP_IDLE** when no strobe is present (transition *no_strobe*). A strobe in any state takes the same transitions. **HP_READ** is the cycle in which the read data is valid.

Top module: `idebm_regs`

## Requirements
- R1: After reset, every register reads 0x00, `irq_out` is low and `host_rvalid` is low.
- R2: `host_addr[3]` selects the channel. `host_addr[1:0]` selects the register: 0 is command, 1 is mode, 2 is status and 3 is timing. An access with `host_addr[2]`=1 writes nothing and reads 0x00.
- R3: Each channel's command byte stores the full written byte and reads it back. It has no other effect.
- R4: A mode write through either window changes only bit 4 (block channel 0) and bit 5 (block channel 1). Both windows read the same mode byte.
- R5: Mode bit 2 (channel 0 pending) and bit 3 (channel 1 pending) equal the level of `chan_irq[0]` and `chan_irq[1]` sampled at the previous clock edge.
- R6: `irq_out` = (bit2 AND NOT bit4) OR (bit3 AND NOT bit5) of the mode byte. It changes in the same cycle as the mode byte.
- R7: A status write sets bits 6:5 from the data and keeps bit 0. It clears bit 1 or bit 2 where the data bit is 1 and keeps it otherwise. Bits 7, 4 and 3 read 0.
- R8: `eng_set[3c+2:3c]` sets status bits 2:0 of channel c at the clock edge. In the same cycle, a set wins over a host clear.
- R9: The timing byte at offset 3 is stored separately for each channel.
- R10: Read data appears on `host_rdata` in the cycle after the read strobe, and `host_rvalid` is high for exactly that cycle. Reads change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_sel | input | 1 | Access strobe, one cycle per byte |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 4 | Byte address: bit 3 channel, bits 1:0 register |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid while host_rvalid |
| host_rvalid | output | 1 | High in the cycle after a read strobe |
| eng_set | input | 6 | Status set pulses from the engine, 3 bits per channel |
| chan_irq | input | 2 | Channel interrupt levels |
| irq_out | output | 1 | Combined level interrupt |

## Verification
The assertions assume that `host_sel`, `host_we`, `chan_irq` and `eng_set` change only between clock edges and never take unknown values after reset. They also assume that `eng_set` and a host status clear of the same bit may share a cycle only under the set-wins rule. The bench drives every input on the falling edge and holds each strobe for exactly one cycle. It releases reset only after the inputs are defined. In the one scenario that overlaps an engine set with a host clear, it applies them together on purpose.

// File: rtl/idebm_pkg.sv
package idebm_pkg;

    typedef enum logic [1:0] {
        REG_CMD  = 2'd0,
        REG_MODE = 2'd1,
        REG_STAT = 2'd2,
        REG_TIME = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        HP_IDLE  = 2'd0,
        HP_READ  = 2'd1,
        HP_WRITE = 2'd2
    } hp_state_e;

    localparam int PEND_LSB = 2;
    localparam int STAT_W   = 3;

endpackage

// File: rtl/idebm_host_fsm.sv
module idebm_host_fsm
    import idebm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic we,
    output logic rd_fire,
    output logic wr_fire,
    output logic rvalid
);
    hp_state_e state_q, state_d;

    always_comb begin
        state_d = HP_IDLE;
        unique case ({sel, we})
            2'b10:   state_d = HP_READ;
            2'b11:   state_d = HP_WRITE;
            default: state_d = HP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        rd_fire = sel && !we;
        wr_fire = sel && we;
        rvalid  = (state_q == HP_READ);
    end

    assert_rvalid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !we) |=> rvalid);
    assert_rvalid_only_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && !we) |=> !rvalid);
endmodule

// File: rtl/idebm_mode_reg.sv
module idebm_mode_reg
    import idebm_pkg::*;
#(
    parameter int CH_COUNT = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CH_COUNT-1:0] irq_in,
    input  logic                wr_en,
    input  logic [CH_COUNT-1:0] blk_wdata,
    output logic [7:0]          mode_byte,
    output logic [CH_COUNT-1:0] blk,
    output logic                irq_out
);
    localparam int BLK_LSB = PEND_LSB + CH_COUNT;

    logic [CH_COUNT-1:0] pend_q, blk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            blk_q  <= '0;
        end else begin
            pend_q <= irq_in;
            if (wr_en) blk_q <= blk_wdata;
        end
    end

    always_comb begin
        mode_byte = 8'h00;
        mode_byte[PEND_LSB +: CH_COUNT] = pend_q;
        mode_byte[BLK_LSB  +: CH_COUNT] = blk_q;
        irq_out = |(pend_q & ~blk_q);
        blk     = blk_q;
    end

    assert_pend_tracks_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend_q == $past(irq_in)));
    assert_block_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(blk_q));
endmodule

// File: rtl/idebm_chan_regs.sv
module idebm_chan_regs
    import idebm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          reg_sel,
    input  logic [7:0]        wdata,
    input  logic [STAT_W-1:0] eng_set,
    output logic [7:0]        cmd,
    output logic [7:0]        stat,
    output logic [7:0]        timing
);
    logic [7:0] cmd_q, stat_q, time_q, stat_d;

    always_comb begin
        stat_d = stat_q;
        if (wr_en && reg_sel == REG_STAT)
            stat_d = {1'b0, wdata[6:5], 2'b00, stat_q[2:1] & ~wdata[2:1], stat_q[0]};
        stat_d[STAT_W-1:0] = stat_d[STAT_W-1:0] | eng_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= 8'h00;
            stat_q <= 8'h00;
            time_q <= 8'h00;
        end else begin
            stat_q <= stat_d;
            if (wr_en && reg_sel == REG_CMD)  cmd_q  <= wdata;
            if (wr_en && reg_sel == REG_TIME) time_q <= wdata;
        end
    end

    assign cmd    = cmd_q;
    assign stat   = stat_q;
    assign timing = time_q;

    assert_stat_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == REG_STAT && wdata[1] && !eng_set[1]) |=> !stat_q[1]);
    assert_stat_bit0_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_set[0]) |=> (stat_q[0] == $past(stat_q[0])));
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eng_set[2] |=> stat_q[2]);
    assert_timing_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == REG_TIME) |=> (time_q == $past(wdata)));
endmodule

// File: rtl/idebm_regs.sv
module idebm_regs
    import idebm_pkg::*;
#(
    parameter int CH_COUNT   = 2,
    parameter int WIN_STRIDE = 8,
    parameter int WIN_REGS   = 4,
    parameter int AW         = $clog2(CH_COUNT * WIN_STRIDE)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_sel,
    input  logic                       host_we,
    input  logic [AW-1:0]              host_addr,
    input  logic [7:0]                 host_wdata,
    output logic [7:0]                 host_rdata,
    output logic                       host_rvalid,
    input  logic [STAT_W*CH_COUNT-1:0] eng_set,
    input  logic [CH_COUNT-1:0]        chan_irq,
    output logic                       irq_out
);
    localparam int OFF_W = $clog2(WIN_STRIDE);
    localparam int CH_W  = AW - OFF_W;

    logic              rd_fire, wr_fire;
    logic [CH_W-1:0]   ch_idx;
    logic [OFF_W-1:0]  off;
    logic              in_win;
    reg_sel_e          reg_sel;
    logic [7:0]        mode_byte, rd_mux;
    logic [CH_COUNT-1:0] blk;
    logic [7:0] cmd_v  [CH_COUNT];
    logic [7:0] stat_v [CH_COUNT];
    logic [7:0] time_v [CH_COUNT];

    assign ch_idx  = host_addr[AW-1:OFF_W];
    assign off     = host_addr[OFF_W-1:0];
    assign in_win  = (int'(off) < WIN_REGS) && (int'(ch_idx) < CH_COUNT);
    assign reg_sel = reg_sel_e'(off[1:0]);

    idebm_host_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sel(host_sel), .we(host_we),
        .rd_fire(rd_fire), .wr_fire(wr_fire), .rvalid(host_rvalid)
    );

    idebm_mode_reg #(.CH_COUNT(CH_COUNT)) u_mode (
        .clk(clk), .rst_n(rst_n), .irq_in(chan_irq),
        .wr_en(wr_fire && in_win && reg_sel == REG_MODE),
        .blk_wdata(host_wdata[PEND_LSB+CH_COUNT +: CH_COUNT]),
        .mode_byte(mode_byte), .blk(blk), .irq_out(irq_out)
    );

    for (genvar g = 0; g < CH_COUNT; g++) begin : g_ch
        idebm_chan_regs u_ch (
            .clk(clk), .rst_n(rst_n),
            .wr_en(wr_fire && in_win && (int'(ch_idx) == g) && reg_sel != REG_MODE),
            .reg_sel(reg_sel), .wdata(host_wdata),
            .eng_set(eng_set[g*STAT_W +: STAT_W]),
            .cmd(cmd_v[g]), .stat(stat_v[g]), .timing(time_v[g])
        );
    end

    always_comb begin
        rd_mux = 8'h00;
        for (int i = 0; i < CH_COUNT; i++) begin
            if (in_win && int'(ch_idx) == i) begin
                unique case (reg_sel)
                    REG_CMD:  rd_mux = cmd_v[i];
                    REG_MODE: rd_mux = mode_byte;
                    REG_STAT: rd_mux = stat_v[i];
                    REG_TIME: rd_mux = time_v[i];
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       host_rdata <= 8'h00;
        else if (rd_fire) host_rdata <= rd_mux;
    end

    assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (&blk) |-> !irq_out);
    assert_irq_needs_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(chan_irq) == '0) |-> !irq_out);
endmodule

// File: tb/tb_idebm_regs.sv
module tb_idebm_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sel = 1'b0, host_we = 1'b0;
    logic [3:0] host_addr = 4'h0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       host_rvalid;
    logic [5:0] eng_set = 6'h0;
    logic [1:0] chan_irq = 2'b00;
    logic       irq_out;
    int checks = 0, errors = 0, cyc = 0;

    always #10 clk = ~clk;

    idebm_regs dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .eng_set(eng_set), .chan_irq(chan_irq),
        .irq_out(irq_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_sel = 1'b0; host_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_we = 1'b0; host_addr = a;
        @(negedge clk);
        host_sel = 1'b0;
        d = host_rdata;
        check("R10 rvalid", int'(host_rvalid), 1);
        @(negedge clk);
        check("R10 rvalid drop", int'(host_rvalid), 0);
    endtask

    task automatic rd_check(input string req, input logic [3:0] a, input logic [7:0] e);
        logic [7:0] d;
        rd(a, d);
        check(req, int'(d), int'(e));
    endtask

    task automatic t_reset();
        for (int a = 0; a < 16; a++) rd_check("R1 reset", 4'(a), 8'h00);
        check("R1 irq", int'(irq_out), 0);
    endtask

    task automatic t_command();
        wr(4'h0, 8'hA5);
        wr(4'h8, 8'h3C);
        rd_check("R3 cmd ch0", 4'h0, 8'hA5);
        rd_check("R3 cmd ch1", 4'h8, 8'h3C);
        check("R3 no irq", int'(irq_out), 0);
    endtask

    task automatic t_mode();
        wr(4'h1, 8'hFF);
        rd_check("R4 mode ch0", 4'h1, 8'h30);
        rd_check("R4 mode ch1 window", 4'h9, 8'h30);
        wr(4'h9, 8'h10);
        rd_check("R4 mode after ch1 write", 4'h1, 8'h10);
        wr(4'h1, 8'h00);
    endtask

    task automatic t_irq();
        @(negedge clk); chan_irq = 2'b01;
        @(negedge clk);
        check("R6 ch0 pending", int'(irq_out), 1);
        rd_check("R5 pend ch0", 4'h1, 8'h04);
        wr(4'h1, 8'h10);
        check("R6 ch0 blocked", int'(irq_out), 0);
        chan_irq = 2'b11;
        @(negedge clk);
        check("R6 ch1 passes", int'(irq_out), 1);
        rd_check("R5 both pend", 4'h9, 8'h1C);
        wr(4'h1, 8'h30);
        check("R6 both blocked", int'(irq_out), 0);
        wr(4'h1, 8'h20);
        check("R6 ch0 unblocked", int'(irq_out), 1);
        chan_irq = 2'b00;
        @(negedge clk);
        check("R5 follows low", int'(irq_out), 0);
        rd_check("R5 pend cleared", 4'h1, 8'h20);
        wr(4'h1, 8'h00);
    endtask

    task automatic t_status();
        @(negedge clk); eng_set = 6'b000_111;
        @(negedge clk); eng_set = 6'h0;
        rd_check("R8 set ch0", 4'h2, 8'h07);
        rd_check("R8 ch1 untouched", 4'hA, 8'h00);
        wr(4'h2, 8'h62);
        rd_check("R7 write 62", 4'h2, 8'h65);
        wr(4'h2, 8'h9C);
        rd_check("R7 write 9C", 4'h2, 8'h01);
        @(negedge clk);
        host_sel = 1'b1; host_we = 1'b1; host_addr = 4'hA; host_wdata = 8'h02;
        eng_set = 6'b010_000;
        @(negedge clk);
        host_sel = 1'b0; host_we = 1'b0; eng_set = 6'h0;
        rd_check("R8 set beats clear", 4'hA, 8'h02);
        wr(4'hA, 8'h02);
        rd_check("R7 clear ch1 bit1", 4'hA, 8'h00);
    endtask

    task automatic t_timing();
        wr(4'h3, 8'h5A);
        wr(4'hB, 8'hC3);
        rd_check("R9 time ch0", 4'h3, 8'h5A);
        rd_check("R9 time ch1", 4'hB, 8'hC3);
    endtask

    task automatic t_unmapped();
        wr(4'h4, 8'hEE);
        wr(4'hD, 8'hEE);
        rd_check("R2 hole read", 4'h4, 8'h00);
        rd_check("R2 cmd ch0 kept", 4'h0, 8'hA5);
        rd_check("R2 stat ch1 kept", 4'hA, 8'h00);
        rd_check("R2 mode kept", 4'h1, 8'h00);
        rd_check("R2 time ch1 kept", 4'hB, 8'hC3);
    endtask

    task automatic t_read_quiet();
        rd_check("R10 stat read 1", 4'h2, 8'h01);
        rd_check("R10 stat read 2", 4'h2, 8'h01);
        check("R1 rvalid idle", int'(host_rvalid), 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 irq in reset", int'(irq_out), 0);
        rst_n = 1'b1;
        t_reset();
        t_command();
        t_mode();
        t_irq();
        t_status();
        t_timing();
        t_unmapped();
        t_read_quiet();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule